// File: doc/BRIEF.md
# Codec ADC Word-Clock Pin Mode Controller

This block decides how the bidirectional ADC word-clock pad of an audio codec behaves. A two-bit pin-mode field, held in one configuration register, chooses between two kinds of use. In the first, the pad carries the ADC left/right frame clock. It is driven when the codec is the clock master and left as an input when the codec is a slave. In the other kinds of use, the pad is taken over as a clock output. It then carries the raw master clock, the master clock divided by 5.5, or the master clock divided by 6.

While the pad is a clock output, the ADC framing logic can no longer read its frame clock there. The block therefore hands it the DAC word clock in its place. The block also produces the pad output-enable and the pad drive value. The pad cell itself and the sample-rate dividers sit outside it. The fractional divide is built from alternating 5-cycle and 6-cycle output periods. Both dividers restart whenever the mode field changes.

Top module: `wclk_pin_ctrl`

## Requirements
- R1: After reset the pin-mode field is 00, so the block behaves as in R3 and R4.
- R2: A write with `cfg_wr`=1 and `cfg_addr`=27 loads the pin mode from `cfg_wdata[8:7]` at the clock edge. A write to any other address leaves the mode unchanged.
- R3: In mode 00 with `is_master`=1 and `tri_req`=0, `pin_oe`=1, `pin_out` follows `adc_wclk_int`, and `adc_lrclk` follows `adc_wclk_int`.
- R4: In mode 00, `pin_oe`=0 whenever `is_master`=0 or `tri_req`=1. As a slave, `adc_lrclk` follows `pin_in`.
- R5: In modes 01, 10 and 11, `pin_oe`=1 whatever the values of `is_master` and `tri_req`.
- R6: In modes 01, 10 and 11, `adc_lrclk` follows `dac_wclk` in both master and slave operation.
- R7: In mode 01, `pin_out` equals the master clock `mclk`.
- R8: In mode 11, `pin_out` repeats 3 cycles high then 3 cycles low.
- R9: In mode 10, `pin_out` repeats an 11-cycle pattern of 3 high, 2 low, 3 high, 3 low, giving an average period of 5.5 cycles.
- R10: A write that changes the mode restarts both dividers. In the first cycle after that edge, each divider is at the first high cycle of its pattern. A write that keeps the same mode does not disturb the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; also the raw clock output of mode 01 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration register address |
| cfg_wdata | input | 9 | Configuration write data; pin mode in bits [8:7] |
| is_master | input | 1 | 1 = codec is clock master, 0 = slave |
| tri_req | input | 1 | Tristate request for the codec's interface pins |
| adc_wclk_int | input | 1 | Internally generated ADC word clock (master operation) |
| pin_in | input | 1 | Value received from the ADC word-clock pad |
| dac_wclk | input | 1 | DAC word clock from its own pad |
| pin_oe | output | 1 | Output enable for the ADC word-clock pad |
| pin_out | output | 1 | Drive value for the ADC word-clock pad |
| adc_lrclk | output | 1 | Frame clock delivered to the ADC framing logic |

## Verification
Directed sequences walk every master/slave and tristate combination in the word-clock mode and again in a clock-output mode. This separates the normal input/output rule from the forced-drive rule, and shows which of the pad, internal or DAC clock reaches the ADC. The divided outputs are compared cycle by cycle against bench-computed patterns. The checks start right after a mode-changing write, which exposes the restart, and continue across a same-mode rewrite, which must leave the phase alone. Random input values, mixed with random writes to the register and to other addresses, check the enable and clock selection and show that stray addresses cannot alter the mode.

// File: rtl/wclk_pkg.sv
package wclk_pkg;
   typedef enum logic [1:0] {
      PM_WORDCLK = 2'b00,
      PM_MCLK    = 2'b01,
      PM_DIV55   = 2'b10,
      PM_DIV6    = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/wclk_cfg_reg.sv
module wclk_cfg_reg
   import wclk_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 9,
   parameter int REG_ADDR  = 27,
   parameter int FIELD_LSB = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output pin_mode_e         mode_q,
   output logic              restart
);
   localparam int FIELD_MSB = FIELD_LSB + 1;
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   generate
      if (FIELD_MSB >= DATA_W) begin : g_bad_field
         $error("pin-mode field does not fit in write data");
      end
      if (REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("register address does not fit in address width");
      end
   endgenerate

   logic      hit;
   pin_mode_e new_mode;
   logic      unused_wdata;

   assign hit          = wr_en && (addr == HIT_ADDR);
   assign new_mode     = pin_mode_e'(wdata[FIELD_MSB:FIELD_LSB]);
   assign restart      = hit && (new_mode != mode_q);
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mode_q <= PM_WORDCLK;
      else if (hit) mode_q <= new_mode;
   end

   // R2: a write to the register address loads the field
   p_load_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (mode_q == $past(new_mode)));
   // R2: writes elsewhere leave the mode alone
   p_ignore_other_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(mode_q));
endmodule

// File: rtl/wclk_clk_div.sv
module wclk_clk_div #(
   parameter int PER_A = 5,
   parameter int HI_A  = 3,
   parameter int PER_B = 6,
   parameter int HI_B  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic clk_out
);
   localparam bit TWO_PHASE = (PER_A != PER_B) || (HI_A != HI_B);
   localparam int LEN       = TWO_PHASE ? (PER_A + PER_B) : PER_A;
   localparam int CW        = (LEN > 2) ? $clog2(LEN) : 1;
   localparam int MAX_HI    = (HI_A > HI_B) ? HI_A : HI_B;
   localparam int MAX_LO    = ((PER_A - HI_A) > (PER_B - HI_B)) ? (PER_A - HI_A) : (PER_B - HI_B);
   localparam logic [CW-1:0] LAST    = CW'(LEN - 1);
   localparam logic [CW-1:0] C_HI_A  = CW'(HI_A);
   localparam logic [CW-1:0] C_PER_A = CW'(PER_A);
   localparam logic [CW-1:0] C_B_HI  = CW'(PER_A + HI_B);

   generate
      if (PER_A < 2 || PER_B < 2) begin : g_bad_per
         $error("divider periods must be at least 2");
      end
      if (HI_A < 1 || HI_A >= PER_A || HI_B < 1 || HI_B >= PER_B) begin : g_bad_hi
         $error("high phase must be inside its period");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          hi_nxt;

   assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

   generate
      if (TWO_PHASE) begin : g_two
         assign hi_nxt = (cnt_nxt < C_PER_A) ? (cnt_nxt < C_HI_A) : (cnt_nxt < C_B_HI);
      end else begin : g_one
         assign hi_nxt = (cnt_nxt < C_HI_A);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         clk_out <= 1'b1;
      end else if (restart) begin
         cnt_q   <= '0;
         clk_out <= 1'b1;
      end else begin
         cnt_q   <= cnt_nxt;
         clk_out <= hi_nxt;
      end
   end

   // run-length counters for the phase-length checks
   logic [CW:0] hi_run, lo_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
      end else if (restart) begin
         hi_run <= '0;
         lo_run <= '0;
      end else if (clk_out) begin
         hi_run <= hi_run + 1'b1;
         lo_run <= '0;
      end else begin
         lo_run <= lo_run + 1'b1;
         hi_run <= '0;
      end
   end

   // R8/R9: no high phase longer than the longest programmed one
   p_high_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hi_run <= (CW+1)'(MAX_HI));
   // R8/R9: no low phase longer than the longest programmed one
   p_low_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lo_run <= (CW+1)'(MAX_LO));
   // R10: a restart lands on the first high cycle
   p_restart_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> clk_out);
endmodule

// File: rtl/wclk_pin_mux.sv
module wclk_pin_mux
   import wclk_pkg::*;
(
   input  pin_mode_e mode,
   input  logic      is_master,
   input  logic      tri_req,
   input  logic      mclk,
   input  logic      div55,
   input  logic      div6,
   input  logic      adc_wclk_int,
   input  logic      pin_in,
   input  logic      dac_wclk,
   output logic      pin_oe,
   output logic      pin_out,
   output logic      adc_lrclk
);
   always_comb begin
      case (mode)
         PM_MCLK: begin
            pin_oe    = 1'b1;
            pin_out   = mclk;
            adc_lrclk = dac_wclk;
         end
         PM_DIV55: begin
            pin_oe    = 1'b1;
            pin_out   = div55;
            adc_lrclk = dac_wclk;
         end
         PM_DIV6: begin
            pin_oe    = 1'b1;
            pin_out   = div6;
            adc_lrclk = dac_wclk;
         end
         default: begin
            pin_oe    = is_master && !tri_req;
            pin_out   = adc_wclk_int;
            adc_lrclk = is_master ? adc_wclk_int : pin_in;
         end
      endcase
   end
endmodule

// File: rtl/wclk_pin_ctrl.sv
module wclk_pin_ctrl
   import wclk_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 9,
   parameter int REG_ADDR  = 27,
   parameter int FIELD_LSB = 7
) (
   input  logic              mclk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              is_master,
   input  logic              tri_req,
   input  logic              adc_wclk_int,
   input  logic              pin_in,
   input  logic              dac_wclk,
   output logic              pin_oe,
   output logic              pin_out,
   output logic              adc_lrclk
);
   pin_mode_e mode;
   logic      restart;
   logic      div55;
   logic      div6;

   wclk_cfg_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .FIELD_LSB(FIELD_LSB)
   ) cfg_i (
      .clk(mclk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
      .wdata(cfg_wdata), .mode_q(mode), .restart(restart)
   );

   wclk_clk_div #(.PER_A(5), .HI_A(3), .PER_B(6), .HI_B(3)) div55_i (
      .clk(mclk), .rst_n(rst_n), .restart(restart), .clk_out(div55)
   );

   wclk_clk_div #(.PER_A(6), .HI_A(3), .PER_B(6), .HI_B(3)) div6_i (
      .clk(mclk), .rst_n(rst_n), .restart(restart), .clk_out(div6)
   );

   wclk_pin_mux mux_i (
      .mode(mode), .is_master(is_master), .tri_req(tri_req), .mclk(mclk),
      .div55(div55), .div6(div6), .adc_wclk_int(adc_wclk_int), .pin_in(pin_in),
      .dac_wclk(dac_wclk), .pin_oe(pin_oe), .pin_out(pin_out), .adc_lrclk(adc_lrclk)
   );

   // R5: clock-output modes always drive the pad
   p_force_drive_r5: assert property (@(posedge mclk) disable iff (!rst_n)
      (mode != PM_WORDCLK) |-> pin_oe);
   // R6: clock-output modes frame the ADC from the DAC word clock
   p_lrclk_dac_r6: assert property (@(posedge mclk) disable iff (!rst_n)
      (mode != PM_WORDCLK) |-> (adc_lrclk == dac_wclk));
   // R4: the word-clock mode never drives while tristate is requested
   p_tri_release_r4: assert property (@(posedge mclk) disable iff (!rst_n)
      ((mode == PM_WORDCLK) && tri_req) |-> !pin_oe);
   // R1: the first cycle after reset is in the word-clock mode
   p_reset_mode_r1: assert property (@(posedge mclk)
      !rst_n |=> (mode == PM_WORDCLK));
endmodule

// File: tb/wclk_pin_ctrl_tb_top.sv
module wclk_pin_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int REG_A      = 27;

   logic       mclk = 1'b0;
   logic       rst_n;
   logic       cfg_wr;
   logic [6:0] cfg_addr;
   logic [8:0] cfg_wdata;
   logic       is_master, tri_req, adc_wclk_int, pin_in, dac_wclk;
   logic       pin_oe, pin_out, adc_lrclk;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;
   logic [1:0] mdl_mode;

   always #(CLK_PERIOD/2) mclk = ~mclk;

   wclk_pin_ctrl dut_i (
      .mclk(mclk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .is_master(is_master), .tri_req(tri_req),
      .adc_wclk_int(adc_wclk_int), .pin_in(pin_in), .dac_wclk(dac_wclk),
      .pin_oe(pin_oe), .pin_out(pin_out), .adc_lrclk(adc_lrclk)
   );

   task automatic chk(input logic got, input logic exp, input string what);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%b exp=%b at %0t", what, got, exp, $time);
      end
   endtask

   function automatic logic f_oe(logic [1:0] m, logic mst, logic tr);
      return (m != 2'b00) ? 1'b1 : (mst && !tr);
   endfunction

   function automatic logic f_lr(logic [1:0] m, logic mst, logic ai, logic pi, logic dw);
      if (m != 2'b00) return dw;
      return mst ? ai : pi;
   endfunction

   function automatic logic f_div6(int k);
      return (k % 6) < 3;
   endfunction

   function automatic logic f_div55(int k);
      int p;
      p = k % 11;
      return (p < 3) || (p >= 5 && p < 8);
   endfunction

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [6:0] a, input logic [8:0] d);
      cfg_wr    = 1'b1;
      cfg_addr  = a;
      cfg_wdata = d;
      @(negedge mclk);
      cfg_wr = 1'b0;
      if (a == 7'(REG_A)) mdl_mode = d[8:7];
   endtask

   task automatic chk_comb(input string tag);
      #1;
      chk(pin_oe, f_oe(mdl_mode, is_master, tri_req), {tag, " pin_oe"});
      chk(adc_lrclk, f_lr(mdl_mode, is_master, adc_wclk_int, pin_in, dac_wclk), {tag, " adc_lrclk"});
      if (mdl_mode == 2'b00) chk(pin_out, adc_wclk_int, {tag, " pin_out word clock"});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(1234));
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      is_master = 1'b0; tri_req = 1'b0; adc_wclk_int = 1'b0; pin_in = 1'b0; dac_wclk = 1'b0;
      mdl_mode = 2'b00;
      repeat (3) @(negedge mclk);
      rst_n = 1'b1;
      @(negedge mclk);

      // R1: reset state is word-clock mode
      #1 chk(pin_oe, 1'b0, "R1 slave after reset pin_oe");
      is_master = 1'b1; adc_wclk_int = 1'b1;
      #1 chk(pin_oe, 1'b1, "R1 master after reset pin_oe");
      chk(pin_out, 1'b1, "R1 master after reset pin_out");

      // R2: write to another address is ignored
      @(negedge mclk);
      wr(7'd5, 9'h180);
      is_master = 1'b0;
      #1 chk(pin_oe, 1'b0, "R2 other address ignored pin_oe");
      pin_in = 1'b1; dac_wclk = 1'b0;
      #1 chk(adc_lrclk, 1'b1, "R2 other address ignored adc_lrclk");

      // R3: master drives internal word clock
      is_master = 1'b1; tri_req = 1'b0;
      for (int v = 0; v < 2; v++) begin
         adc_wclk_int = v[0]; pin_in = ~v[0];
         #1;
         chk(pin_oe, 1'b1, "R3 master pin_oe");
         chk(pin_out, v[0], "R3 master pin_out");
         chk(adc_lrclk, v[0], "R3 master adc_lrclk");
      end

      // R4: slave or tristate releases the pad
      is_master = 1'b0;
      for (int v = 0; v < 2; v++) begin
         pin_in = v[0]; adc_wclk_int = ~v[0];
         #1;
         chk(pin_oe, 1'b0, "R4 slave pin_oe");
         chk(adc_lrclk, v[0], "R4 slave adc_lrclk from pad");
      end
      is_master = 1'b1; tri_req = 1'b1;
      #1 chk(pin_oe, 1'b0, "R4 master tristate pin_oe");

      // R8/R10: mode 11 (cfg_wdata[8:7]=11), restart then 3H3L
      @(negedge mclk);
      wr(7'(REG_A), 9'h180);
      for (int k = 0; k < 18; k++) begin
         chk(pin_out, f_div6(k), $sformatf("R8 R10 div6 cycle %0d", k));
         @(negedge mclk);
      end

      // R5/R6 in a clock-output mode
      for (int v = 0; v < 4; v++) begin
         is_master = v[0]; tri_req = v[1]; dac_wclk = v[0] ^ v[1]; pin_in = ~dac_wclk;
         #1;
         chk(pin_oe, 1'b1, "R5 forced drive pin_oe");
         chk(adc_lrclk, dac_wclk, "R6 adc_lrclk from dac_wclk");
      end

      // R9/R10: mode 10 pattern 3H2L3H3L
      @(negedge mclk);
      wr(7'(REG_A), 9'h100);
      for (int k = 0; k < 33; k++) begin
         chk(pin_out, f_div55(k), $sformatf("R9 R10 div55 cycle %0d", k));
         @(negedge mclk);
      end
      // R10: same-mode rewrite keeps phase (now at index 33, write lands by 34)
      wr(7'(REG_A), 9'h17F);
      for (int k = 34; k < 45; k++) begin
         chk(pin_out, f_div55(k), $sformatf("R10 same-mode no restart cycle %0d", k));
         @(negedge mclk);
      end

      // R7: mode 01 passes the master clock
      wr(7'(REG_A), 9'h080);
      for (int k = 0; k < 3; k++) begin
         #1 chk(pin_out, 1'b0, "R7 mclk low phase");
         @(posedge mclk);
         #1 chk(pin_out, 1'b1, "R7 mclk high phase");
         @(negedge mclk);
      end

      // random mix: R2 R4 R5 R6 R3
      for (int it = 0; it < 400; it++) begin
         if (($urandom % 4) == 0) begin
            logic [6:0] a;
            a = (($urandom % 2) == 0) ? 7'(REG_A) : 7'($urandom);
            wr(a, 9'($urandom));
         end
         is_master    = 1'($urandom);
         tri_req      = 1'($urandom);
         adc_wclk_int = 1'($urandom);
         pin_in       = 1'($urandom);
         dac_wclk     = 1'($urandom);
         chk_comb("R2 R3 R4 R5 R6 random");
         @(negedge mclk);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule